// File: doc/BRIEF.md
# Digital Video Active-Line Extractor

This block takes an 8-bit component digital video byte stream (ITU-R BT.656 style) and finds the four-byte timing codes embedded in it. Each timing code is the three bytes FF, 00, 00 followed by a status byte. The block opens a line at a start code and closes it at the matching end code. It passes on only the picture bytes in between. Blanking filler and the timing codes themselves never reach the output.

Each received line is held in an internal line store until its end code arrives. A line with exactly the configured number of active bytes (1440 by default, which is 720 pixels of 4:2:2) is then drained to the output. Each byte is tagged with its colour component, line start, line end and field parity. A line of any other length raises a one-cycle error pulse and is discarded whole.

Both data sides use valid/ready:
- **Input side:** a byte moves only in a cycle where `in_valid` and `in_ready` are both high. `in_ready` is low for as long as a completed line is being drained.
- **Output side:** `out_valid` stays high and every output field stays unchanged until `out_ready` takes the byte.

Top module: `bt656_line_framer`

## Requirements
- R1: While reset is asserted, `in_ready` is 1, `out_valid` is 0 and `line_err` is 0.
- R2: A timing code is FF, 00, 00 and a status byte in four consecutive accepted bytes. A status upper nibble of 8 opens a line of field 0 (odd). A status upper nibble of C opens a line of field 1 (even). `out_field` carries the field of the opening code.
- R3: A status upper nibble of 9 or D closes the open line. If exactly ACTIVE_BYTES bytes lay between the two codes, those bytes are emitted in arrival order. After the last of them, `out_valid` drops.
- R4: `out_comp` is 0 on the first emitted byte of a line and then counts 0,1,2,3 (Cb, Y, Cr, Y) cyclically. `out_sol` is 1 only on the first byte and `out_eol` is 1 only on the last byte.
- R5: Bytes received outside an open line are never emitted, including the 80/10 blanking filler. A closing code with no open line has no effect.
- R6: If a closing code arrives after any count other than ACTIVE_BYTES, `line_err` pulses high for exactly one cycle and no byte of that line is emitted.
- R7: An opening code that arrives while a line is open pulses `line_err`, discards the open line and starts a new line.
- R8: An FF byte that is not followed by 00, 00 in the next accepted bytes is ordinary picture data. The same holds for FF, 00 followed by a nonzero byte.
- R9: During output stall (`out_valid` high, `out_ready` low), `out_data`, `out_comp` and the flags hold. `in_ready` is never high in a cycle where `out_valid` is high.
- R10: A status byte with any other upper nibble (0 to 7, A, B, E, F) neither opens nor closes a line. Inside an open line, all four bytes of such a code count as picture data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input byte present |
| in_ready | output | 1 | Block can accept an input byte |
| in_data | input | 8 | Input video byte |
| out_valid | output | 1 | Output byte present |
| out_ready | input | 1 | Downstream takes the output byte |
| out_data | output | 8 | Active picture byte |
| out_comp | output | 2 | Component tag: 0 Cb, 1 Y, 2 Cr, 3 Y |
| out_field | output | 1 | Field parity of the line: 0 odd, 1 even |
| out_sol | output | 1 | First byte of the line |
| out_eol | output | 1 | Last byte of the line |
| line_err | output | 1 | One-cycle pulse: malformed or aborted line |

## Verification
Two functions meet on a single accepted status byte: closing or aborting the open line, and opening the next one.

The opening-code case is provoked by sending a second opening code one hundred bytes into a line. It is judged by a single error pulse followed by a clean, full-length line carrying the new field.

The same kind of collision inside the code detector is provoked by near-miss codes placed in the picture data: stray FF bytes, FF 00 followed by data, and a complete code with a non-line status. The emitted line must contain them byte for byte, at the right positions and with the right component tags.

// File: rtl/bt656_pkg.sv
package bt656_pkg;
  localparam int BYTE_W = 8;
  localparam logic [BYTE_W-1:0] SYNC_HI = 8'hFF;
  localparam logic [BYTE_W-1:0] SYNC_LO = 8'h00;
  // number of preamble bytes that precede a status byte
  localparam int SYNC_LEN = 3;

  typedef enum logic [1:0] {
    CODE_NONE,
    CODE_OPEN,
    CODE_CLOSE,
    CODE_OTHER
  } code_kind_t;

  typedef enum logic {
    ST_COLLECT,
    ST_DRAIN
  } framer_state_t;
endpackage

// File: rtl/bt656_code_detect.sv
module bt656_code_detect
  import bt656_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              beat,
  input  logic [BYTE_W-1:0] data,
  output code_kind_t        kind,
  output logic              field
);
  // number of consecutive preamble bytes matched so far
  logic [1:0] match_q;

  always_comb begin
    kind  = CODE_NONE;
    field = data[6];
    if (match_q == 2'(SYNC_LEN)) begin
      // bit7 set and bit5 clear: active-line code; bit4 picks close vs open
      if (data[7] && !data[5])
        kind = data[4] ? CODE_CLOSE : CODE_OPEN;
      else
        kind = CODE_OTHER;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      match_q <= '0;
    end else if (beat) begin
      if (match_q == 2'(SYNC_LEN))
        match_q <= '0;
      else if (data == SYNC_HI)
        match_q <= 2'd1;
      else if (match_q != 2'd0 && data == SYNC_LO)
        match_q <= match_q + 2'd1;
      else
        match_q <= '0;
    end
  end
endmodule

// File: rtl/bt656_line_buf.sv
module bt656_line_buf #(
  parameter int DEPTH = 1443,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/bt656_line_framer.sv
module bt656_line_framer
  import bt656_pkg::*;
#(
  parameter int ACTIVE_BYTES = 1440
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [BYTE_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [BYTE_W-1:0] out_data,
  output logic [1:0]        out_comp,
  output logic              out_field,
  output logic              out_sol,
  output logic              out_eol,
  output logic              line_err
);
  // the closing code's preamble lands in the store before it is recognised
  localparam int DEPTH = ACTIVE_BYTES + SYNC_LEN;
  localparam int AW    = $clog2(DEPTH);
  localparam int CW    = $clog2(DEPTH + 2);

  framer_state_t state_q;
  logic          line_open_q;
  logic          line_field_q;
  logic [CW-1:0] wr_cnt_q;
  logic [AW-1:0] rd_ptr_q;
  logic          err_q;

  logic          beat;
  logic          drain_beat;
  code_kind_t    kind;
  logic          code_field;
  logic          store_we;

  assign in_ready   = (state_q == ST_COLLECT);
  assign beat       = in_valid && in_ready;
  assign out_valid  = (state_q == ST_DRAIN);
  assign drain_beat = out_valid && out_ready;

  bt656_code_detect detect_i (
    .clk   (clk),
    .rst_n (rst_n),
    .beat  (beat),
    .data  (in_data),
    .kind  (kind),
    .field (code_field)
  );

  assign store_we = beat && line_open_q &&
                    (kind == CODE_NONE || kind == CODE_OTHER) &&
                    (wr_cnt_q < CW'(DEPTH));

  bt656_line_buf #(
    .DEPTH (DEPTH),
    .DW    (BYTE_W)
  ) buf_i (
    .clk   (clk),
    .we    (store_we),
    .waddr (wr_cnt_q[AW-1:0]),
    .wdata (in_data),
    .raddr (rd_ptr_q),
    .rdata (out_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= ST_COLLECT;
      line_open_q  <= 1'b0;
      line_field_q <= 1'b0;
      wr_cnt_q     <= '0;
      rd_ptr_q     <= '0;
      err_q        <= 1'b0;
    end else begin
      err_q <= 1'b0;
      unique case (state_q)
        ST_COLLECT: begin
          if (beat) begin
            if (kind == CODE_OPEN) begin
              err_q        <= line_open_q;
              line_open_q  <= 1'b1;
              line_field_q <= code_field;
              wr_cnt_q     <= '0;
            end else if (kind == CODE_CLOSE && line_open_q) begin
              line_open_q <= 1'b0;
              wr_cnt_q    <= '0;
              if (wr_cnt_q == CW'(DEPTH)) begin
                state_q  <= ST_DRAIN;
                rd_ptr_q <= '0;
              end else begin
                err_q <= 1'b1;
              end
            end else if (line_open_q && wr_cnt_q != CW'(DEPTH + 1)) begin
              wr_cnt_q <= wr_cnt_q + CW'(1);
            end
          end
        end
        ST_DRAIN: begin
          if (drain_beat) begin
            if (rd_ptr_q == AW'(ACTIVE_BYTES - 1))
              state_q <= ST_COLLECT;
            else
              rd_ptr_q <= rd_ptr_q + AW'(1);
          end
        end
        default: state_q <= ST_COLLECT;
      endcase
    end
  end

  // the low two bits of the drain pointer act as the component phase
  assign out_comp  = rd_ptr_q[1:0];
  assign out_field = line_field_q;
  assign out_sol   = out_valid && (rd_ptr_q == '0);
  assign out_eol   = out_valid && (rd_ptr_q == AW'(ACTIVE_BYTES - 1));
  assign line_err  = err_q;
endmodule

// File: rtl/bt656_line_framer_chk.sv
module bt656_line_framer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       in_ready,
  input logic       out_valid,
  input logic       out_ready,
  input logic [7:0] out_data,
  input logic [1:0] out_comp,
  input logic       out_sol,
  input logic       out_eol,
  input logic       line_err
);
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_comp));

  assert_no_overlap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> !out_valid);

  assert_first_byte_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> out_sol && out_comp == 2'd0);

  assert_phase_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && !out_eol |=> out_valid && out_comp == 2'($past(out_comp) + 2'd1));

  assert_line_end_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && out_eol |=> !out_valid);

  assert_err_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    line_err |=> !line_err);

  assert_err_no_emit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    line_err |-> !out_valid);
endmodule

bind bt656_line_framer bt656_line_framer_chk chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data),
  .out_comp  (out_comp),
  .out_sol   (out_sol),
  .out_eol   (out_eol),
  .line_err  (line_err)
);

// File: tb/bt656_line_framer_tb_top.sv
`timescale 1ns/1ps
module bt656_line_framer_tb_top;
  localparam int LINE = 1440;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] in_data = 8'h00;
  logic       out_valid;
  logic       out_ready = 1'b1;
  logic [7:0] out_data;
  logic [1:0] out_comp;
  logic       out_field;
  logic       out_sol;
  logic       out_eol;
  logic       line_err;

  always #2.5 clk = ~clk;

  bt656_line_framer #(.ACTIVE_BYTES(LINE)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_comp(out_comp), .out_field(out_field),
    .out_sol(out_sol), .out_eol(out_eol), .line_err(line_err)
  );

  int n_checks = 0;
  int n_errors = 0;

  // expectation of the line currently drained
  int   exp_seed = 0;
  int   exp_inj  = 0;
  logic exp_field = 1'b0;
  logic bp_on = 1'b0;

  int rx_idx = 0;
  int bad_data = 0;
  int bad_frame = 0;
  int hold_bad = 0;
  int stalls = 0;
  int overlap = 0;
  int errp = 0;
  int cyc = 0;
  logic       stall_prev = 1'b0;
  logic [7:0] prev_d = 8'h00;
  logic [1:0] prev_c = 2'd0;

  function automatic logic [7:0] byte_at(int i, int seed, int inj);
    if (inj == 1) begin
      if (i == 10) return 8'hFF;
      if (i == 11) return 8'h00;
      if (i == 12) return 8'h34;
      if (i == 20) return 8'hFF;
    end
    if (inj == 2 && i >= LINE - 4) begin
      case (i - (LINE - 4))
        0: return 8'hFF;
        1: return 8'h00;
        2: return 8'h00;
        default: return 8'hA0;
      endcase
    end
    return 8'(16 + ((i * 3 + seed) % 200));
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // output side: ready is chosen first, then the handshake of the coming edge is judged
  always @(negedge clk) begin
    cyc++;
    out_ready = bp_on ? ((cyc % 3) != 1) : 1'b1;
    if (stall_prev && (out_data !== prev_d || out_comp !== prev_c)) hold_bad++;
    stall_prev = out_valid && !out_ready;
    if (stall_prev) stalls++;
    prev_d = out_data;
    prev_c = out_comp;
    if (out_valid && in_ready) overlap++;
    if (line_err) errp++;
    if (out_valid && out_ready) begin
      if (out_data !== byte_at(rx_idx, exp_seed, exp_inj)) bad_data++;
      if (out_comp !== 2'(rx_idx % 4) || out_sol !== (rx_idx == 0) ||
          out_eol !== (rx_idx == LINE - 1) || out_field !== exp_field) bad_frame++;
      rx_idx++;
    end
    if (cyc > 150000) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  // input side: called at a falling edge, returns at the falling edge after acceptance
  task automatic send(input logic [7:0] b);
    while (!in_ready) @(negedge clk);
    in_data  = b;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic send_code(input logic [7:0] st);
    send(8'hFF); send(8'h00); send(8'h00); send(st);
  endtask

  task automatic blank(input int n);
    for (int i = 0; i < n; i++) send((i % 2 == 0) ? 8'h80 : 8'h10);
  endtask

  task automatic send_line(input logic fld, input int n, input int seed, input int inj);
    send_code(fld ? 8'hC7 : 8'h80);
    for (int i = 0; i < n; i++) send(byte_at(i, seed, inj));
    send_code(fld ? 8'hDA : 8'h9D);
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
    while (out_valid || !in_ready) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic prep(input logic fld, input int seed, input int inj);
    exp_field = fld; exp_seed = seed; exp_inj = inj;
    rx_idx = 0; bad_data = 0; bad_frame = 0; errp = 0;
    hold_bad = 0; stalls = 0; overlap = 0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(in_ready === 1'b1, "R1 in_ready", int'(in_ready), 1);
    check(out_valid === 1'b0, "R1 out_valid", int'(out_valid), 0);
    check(line_err === 1'b0, "R1 line_err", int'(line_err), 0);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_odd_line();
    prep(1'b0, 5, 0);
    blank(16);
    send_line(1'b0, LINE, 5, 0);
    blank(10);
    settle();
    check(rx_idx == LINE, "R3 byte count odd line", rx_idx, LINE);
    check(bad_data == 0, "R3 data order", bad_data, 0);
    check(bad_frame == 0, "R4 comp/sol/eol/field", bad_frame, 0);
    check(errp == 0, "R5 no error on filler", errp, 0);
  endtask

  task automatic t_even_backpressure();
    prep(1'b1, 9, 0);
    bp_on = 1'b1;
    send_line(1'b1, LINE, 9, 0);
    settle();
    bp_on = 1'b0;
    check(rx_idx == LINE, "R2 even line count", rx_idx, LINE);
    check(bad_frame == 0, "R2 even field tag", bad_frame, 0);
    check(bad_data == 0, "R9 data under stall", bad_data, 0);
    check(stalls > 0, "R9 stalls provoked", stalls, 1);
    check(hold_bad == 0, "R9 hold while stalled", hold_bad, 0);
    check(overlap == 0, "R9 in_ready low while draining", overlap, 0);
  endtask

  task automatic t_bad_length(input int n, input string tag);
    prep(1'b0, 3, 0);
    send_line(1'b0, n, 3, 0);
    blank(6);
    settle();
    check(errp == 1, {"R6 error pulse ", tag}, errp, 1);
    check(rx_idx == 0, {"R6 nothing emitted ", tag}, rx_idx, 0);
  endtask

  task automatic t_abort();
    prep(1'b1, 11, 0);
    send_code(8'h80);
    for (int i = 0; i < 100; i++) send(byte_at(i, 2, 0));
    send_line(1'b1, LINE, 11, 0);
    settle();
    check(errp == 1, "R7 abort error", errp, 1);
    check(rx_idx == LINE, "R7 new line emitted", rx_idx, LINE);
    check(bad_data == 0 && bad_frame == 0, "R7 new line content", bad_data + bad_frame, 0);
  endtask

  task automatic t_stray_ff();
    prep(1'b0, 7, 1);
    send_line(1'b0, LINE, 7, 1);
    settle();
    check(rx_idx == LINE, "R8 count with stray FF", rx_idx, LINE);
    check(bad_data == 0, "R8 stray FF kept as data", bad_data, 0);
    check(errp == 0, "R8 no error", errp, 0);
  endtask

  task automatic t_other_codes();
    prep(1'b0, 13, 2);
    blank(8);
    send_code(8'hAB);
    for (int i = 0; i < 20; i++) send(byte_at(i, 1, 0));
    send_code(8'hB6);
    blank(8);
    send_code(8'h9D);
    blank(8);
    settle();
    check(rx_idx == 0, "R10 blanking codes open nothing", rx_idx, 0);
    check(errp == 0, "R5 orphan close ignored", errp, 0);
    send_line(1'b0, LINE, 13, 2);
    settle();
    check(rx_idx == LINE, "R10 inner code counted as data", rx_idx, LINE);
    check(bad_data == 0, "R10 inner code bytes emitted", bad_data, 0);
    check(errp == 0, "R10 no error", errp, 0);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_odd_line();
    t_even_backpressure();
    t_bad_length(LINE - 1, "short");
    t_bad_length(LINE + 1, "long");
    t_abort();
    t_stray_ff();
    t_other_codes();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule